// File: doc/BRIEF.md
# Check-Coded Word Store with Fault Injection

This block keeps a small array of 64-bit words, each stored alongside an 8-bit single-error-correcting, double-error-detecting check code. A write computes the code from the incoming data, XORs it with a programmable injection mask and stores both. A read returns the data one clock later, together with the check code, the syndrome and two error flags.

Fault injection works by setting a nonzero mask. Every word written while the mask is active carries a deliberately damaged code, and that damage survives after the mask is cleared again. Software can therefore drive the detector and the repair path through the normal read port.

Two enable bits govern single-bit errors independently. The report bit latches the first such error into a syndrome/address log and raises an interrupt. The repair bit returns repaired data together with a freshly computed code. Double-bit errors are flagged and are never modified.

Top module: `ecc_mem_guard`

## Requirements
- R1: `rd_valid` is high exactly in the cycle after a cycle with `rd_req` high, and `rd_data`/`rd_code` are valid in that cycle. If a write and a read address the same location in the same cycle, the read returns the previous contents.
- R2: Code layout. Hamming positions run from 1 to 71. Check bit j (j = 0..6) sits at position 2^j and covers every position whose binary index has bit j set. Data bit k occupies the k-th position from 3 upward that is not a power of two, so data bit 0 is at position 3 and data bit 1 is at position 5. Check bit 7 makes the XOR of all 72 stored bits zero. A clean read returns the written data and this code on `rd_code`.
- R3: The stored code equals the computed code XOR the injection mask. The mask, report enable and repair enable all reset to 0. A zero mask stores the code unchanged.
- R4: A word written under a nonzero mask still reads back with an error after the mask has been set back to 0.
- R5: `rd_syndrome[6:0]` is the recomputed 7-bit code XOR the stored bits 6:0. `rd_syndrome[7]` is the XOR of all 72 stored bits. When only the mask has corrupted a word, the syndrome is {^mask, mask[6:0]}.
- R6: `rd_single` is set when `rd_syndrome[7]` is 1 and `rd_syndrome[6:0]` is at most 71. `rd_double` is set for any other nonzero syndrome. The two flags are never set together.
- R7: With repair disabled, a single-bit error returns the stored data and stored code unmodified, with `rd_single` high.
- R8: With repair enabled, a single-bit error inverts the data bit at position `rd_syndrome[6:0]` (when that position holds data), and `rd_code` is the code of the returned data.
- R9: On a double-bit error, `rd_data` and `rd_code` are the stored values, whatever the repair enable is.
- R10: With report enabled, a single-bit read loads `log_syndrome` and `log_addr` and sets `log_valid` on the clock edge that ends the `rd_valid` cycle. This happens only if `log_valid` was clear. The log then holds the first error.
- R11: A register write with `reg_sel`=2 and `reg_wdata[0]`=1 clears `log_valid`. If a capture falls on the same edge, the new error is logged.
- R12: `irq` equals `log_valid` AND report enable. Clearing report enable drops `irq` while the log is kept.
- R13: Register selects: `reg_sel`=0 loads the mask from `reg_wdata`. `reg_sel`=1 loads report enable from bit 0 and repair enable from bit 1. `reg_sel`=3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write location |
| wr_data | input | 64 | Write data |
| rd_req | input | 1 | Read strobe |
| rd_addr | input | 4 | Read location |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Read data, possibly repaired |
| rd_code | output | 8 | Stored or regenerated check code |
| rd_single | output | 1 | Single-bit error on this read |
| rd_double | output | 1 | Uncorrectable error on this read |
| rd_syndrome | output | 8 | Syndrome of this read |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write value |
| log_valid | output | 1 | Log holds an error |
| log_syndrome | output | 8 | Logged syndrome |
| log_addr | output | 4 | Logged location |
| irq | output | 1 | Interrupt |

## Verification
Two things can land on the same clock edge: a log-clear register write and the capture of a new single-bit error from the read in its `rd_valid` cycle. The bench provokes this by issuing the clear exactly in the cycle a damaged word is returned. It passes only if the log then shows the new word's address and syndrome. A write and a read to one location in the same cycle are also forced together, and the returned word must be the old one.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;
   // Hamming position of data bit idx: the idx-th non-power-of-two from 3 up
   function automatic int unsigned data_pos(int unsigned idx);
      int unsigned q;
      int unsigned n;
      int unsigned p;
      q = 2;
      n = 0;
      p = 0;
      while (p == 0) begin
         q = q + 1;
         if ((q & (q - 1)) != 0) begin
            if (n == idx) p = q;
            n = n + 1;
         end
      end
      return p;
   endfunction
endpackage

// File: rtl/ecc_guard_enc.sv
module ecc_guard_enc #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CHK_W  = 8
) (
   input  logic [DATA_W-1:0] data,
   output logic [CHK_W-1:0]  code
);
   localparam int unsigned HAM_W = CHK_W - 1;

   logic [HAM_W-1:0] pos_tab [DATA_W];
   logic [HAM_W-1:0] ham;

   for (genvar i = 0; i < DATA_W; i++) begin : g_pos
      localparam int unsigned P = ecc_guard_pkg::data_pos(i);
      assign pos_tab[i] = HAM_W'(P);
   end

   always_comb begin
      ham = '0;
      for (int j = 0; j < HAM_W; j++) begin
         for (int i = 0; i < DATA_W; i++) begin
            ham[j] = ham[j] ^ (data[i] & pos_tab[i][j]);
         end
      end
   end

   assign code = {^{data, ham}, ham};
endmodule

// File: rtl/ecc_guard_dec.sv
module ecc_guard_dec #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CHK_W  = 8
) (
   input  logic [DATA_W-1:0] data,
   input  logic [CHK_W-1:0]  code,
   output logic [CHK_W-1:0]  syndrome,
   output logic              single,
   output logic              dbl,
   output logic [DATA_W-1:0] fixed
);
   localparam int unsigned HAM_W   = CHK_W - 1;
   localparam logic [HAM_W-1:0] TOP_P = HAM_W'(DATA_W + HAM_W);

   logic [CHK_W-1:0] recalc;
   logic [HAM_W-1:0] s_low;

   ecc_guard_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
      .data (data),
      .code (recalc)
   );

   assign s_low    = recalc[HAM_W-1:0] ^ code[HAM_W-1:0];
   // overall parity of all stored bits, expressed through the recomputed code
   assign syndrome = {recalc[CHK_W-1] ^ code[CHK_W-1] ^ (^s_low), s_low};
   assign single   = syndrome[CHK_W-1] && (s_low <= TOP_P);
   assign dbl      = !single && (syndrome != '0);

   for (genvar i = 0; i < DATA_W; i++) begin : g_fix
      localparam int unsigned P = ecc_guard_pkg::data_pos(i);
      assign fixed[i] = data[i] ^ (single && (s_low == HAM_W'(P)));
   end
endmodule

// File: rtl/ecc_guard_store.sv
module ecc_guard_store #(
   parameter int unsigned WORD_W = 72,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_word,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_word,
   output logic [ADDR_W-1:0] rd_addr_q
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] mem [DEPTH];

   // read-before-write on a same-cycle address match
   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_word;
      if (rd_req) begin
         rd_word   <= mem[rd_addr];
         rd_addr_q <= rd_addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= rd_req;
   end
endmodule

// File: rtl/ecc_guard_log.sv
module ecc_guard_log #(
   parameter int unsigned CHK_W  = 8,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic              clr,
   input  logic [CHK_W-1:0]  cap_syn,
   input  logic [ADDR_W-1:0] cap_addr,
   output logic              log_valid,
   output logic [CHK_W-1:0]  log_syn,
   output logic [ADDR_W-1:0] log_addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         log_valid <= 1'b0;
         log_syn   <= '0;
         log_addr  <= '0;
      end else begin
         if (clr) log_valid <= 1'b0;
         // a fresh error outranks a clear on the same edge
         if (cap && (!log_valid || clr)) begin
            log_valid <= 1'b1;
            log_syn   <= cap_syn;
            log_addr  <= cap_addr;
         end
      end
   end
endmodule

// File: rtl/ecc_mem_guard.sv
module ecc_mem_guard #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CHK_W  = 8,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [CHK_W-1:0]  rd_code,
   output logic              rd_single,
   output logic              rd_double,
   output logic [CHK_W-1:0]  rd_syndrome,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [CHK_W-1:0]  reg_wdata,
   output logic              log_valid,
   output logic [CHK_W-1:0]  log_syndrome,
   output logic [ADDR_W-1:0] log_addr,
   output logic              irq
);
   localparam int unsigned HAM_W  = CHK_W - 1;
   localparam int unsigned WORD_W = DATA_W + CHK_W;

   if (CHK_W < 3) begin : g_bad_chk
      $error("CHK_W must be at least 3");
   end
   if (DATA_W + HAM_W >= (1 << HAM_W)) begin : g_bad_fit
      $error("DATA_W does not fit the Hamming code of CHK_W bits");
   end

   logic [CHK_W-1:0]  mask_q;
   logic              rpt_en;
   logic              cor_en;
   logic              clr_req;
   logic [CHK_W-1:0]  wr_code;
   logic [WORD_W-1:0] raw_word;
   logic [DATA_W-1:0] raw_data;
   logic [CHK_W-1:0]  raw_code;
   logic [ADDR_W-1:0] raw_addr;
   logic [CHK_W-1:0]  syn;
   logic              single;
   logic              dbl;
   logic [DATA_W-1:0] fixed_data;
   logic [CHK_W-1:0]  fixed_code;
   logic              use_fix;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         rpt_en <= 1'b0;
         cor_en <= 1'b0;
      end else if (reg_we) begin
         case (reg_sel)
            2'd0:    mask_q <= reg_wdata;
            2'd1:    {cor_en, rpt_en} <= reg_wdata[1:0];
            default: ;
         endcase
      end
   end

   assign clr_req = reg_we && (reg_sel == 2'd2) && reg_wdata[0];

   ecc_guard_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_wenc (
      .data (wr_data),
      .code (wr_code)
   );

   ecc_guard_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_word   ({wr_code ^ mask_q, wr_data}),
      .rd_req    (rd_req),
      .rd_addr   (rd_addr),
      .rd_valid  (rd_valid),
      .rd_word   (raw_word),
      .rd_addr_q (raw_addr)
   );

   assign raw_code = raw_word[WORD_W-1:DATA_W];
   assign raw_data = raw_word[DATA_W-1:0];

   ecc_guard_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
      .data     (raw_data),
      .code     (raw_code),
      .syndrome (syn),
      .single   (single),
      .dbl      (dbl),
      .fixed    (fixed_data)
   );

   ecc_guard_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_renc (
      .data (fixed_data),
      .code (fixed_code)
   );

   assign use_fix     = cor_en && single;
   assign rd_data     = use_fix ? fixed_data : raw_data;
   assign rd_code     = use_fix ? fixed_code : raw_code;
   assign rd_single   = rd_valid && single;
   assign rd_double   = rd_valid && dbl;
   assign rd_syndrome = syn;

   ecc_guard_log #(.CHK_W(CHK_W), .ADDR_W(ADDR_W)) u_log (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap       (rd_single && rpt_en),
      .clr       (clr_req),
      .cap_syn   (syn),
      .cap_addr  (raw_addr),
      .log_valid (log_valid),
      .log_syn   (log_syndrome),
      .log_addr  (log_addr)
   );

   assign irq = log_valid && rpt_en;
endmodule

// File: rtl/ecc_mem_guard_chk.sv
module ecc_mem_guard_chk #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CHK_W  = 8,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req,
   input logic              rd_valid,
   input logic              rd_single,
   input logic              rd_double,
   input logic [DATA_W-1:0] rd_data,
   input logic [CHK_W-1:0]  rd_code,
   input logic [DATA_W-1:0] raw_data,
   input logic [CHK_W-1:0]  raw_code,
   input logic              cor_en,
   input logic              clr_req,
   input logic              log_valid,
   input logic [CHK_W-1:0]  log_syndrome,
   input logic [ADDR_W-1:0] log_addr,
   input logic              irq
);
   // R1
   read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);
   // R1
   no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);
   // R6
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_single && rd_double));
   // R7
   repair_off_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !cor_en) |-> (rd_data == raw_data && rd_code == raw_code));
   // R9
   double_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_double |-> (rd_data == raw_data && rd_code == raw_code));
   // R10
   log_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (log_valid && !clr_req) |=> (log_valid && $stable(log_addr) && $stable(log_syndrome)));
   // R12
   irq_needs_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> log_valid);
endmodule

bind ecc_mem_guard ecc_mem_guard_chk #(
   .DATA_W (DATA_W),
   .CHK_W  (CHK_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rd_req       (rd_req),
   .rd_valid     (rd_valid),
   .rd_single    (rd_single),
   .rd_double    (rd_double),
   .rd_data      (rd_data),
   .rd_code      (rd_code),
   .raw_data     (raw_data),
   .raw_code     (raw_code),
   .cor_en       (cor_en),
   .clr_req      (clr_req),
   .log_valid    (log_valid),
   .log_syndrome (log_syndrome),
   .log_addr     (log_addr),
   .irq          (irq)
);

// File: tb/sim_ecc_mem_guard.sv
module sim_ecc_mem_guard;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 64;
   localparam int CW = 8;
   localparam int AW = 4;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_req = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic [CW-1:0] rd_code;
   logic          rd_single;
   logic          rd_double;
   logic [CW-1:0] rd_syndrome;
   logic          reg_we = 1'b0;
   logic [1:0]    reg_sel = '0;
   logic [CW-1:0] reg_wdata = '0;
   logic          log_valid;
   logic [CW-1:0] log_syndrome;
   logic [AW-1:0] log_addr;
   logic          irq;

   int nchk = 0;
   int nfail = 0;

   logic [DW-1:0] m_data [DEPTH];
   logic [CW-1:0] m_wmask [DEPTH];
   logic [CW-1:0] m_mask = '0;
   logic          m_rpt = 1'b0;
   logic          m_cor = 1'b0;
   logic          m_logv = 1'b0;
   logic [CW-1:0] m_logs = '0;
   logic [AW-1:0] m_loga = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ecc_mem_guard u0 (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_code(rd_code),
      .rd_single(rd_single), .rd_double(rd_double), .rd_syndrome(rd_syndrome),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .log_valid(log_valid), .log_syndrome(log_syndrome), .log_addr(log_addr),
      .irq(irq)
   );

   function automatic bit is_pow2(int q);
      return (q & (q - 1)) == 0;
   endfunction

   // reference code built by walking Hamming positions
   function automatic logic [CW-1:0] ref_code(logic [DW-1:0] d);
      logic [CW-1:0] c;
      int k;
      c = '0;
      k = 0;
      for (int pos = 3; pos <= DW + CW - 1; pos++) begin
         if (!is_pow2(pos)) begin
            for (int j = 0; j < CW - 1; j++)
               if (((pos >> j) & 1) != 0) c[j] = c[j] ^ d[k];
            k++;
         end
      end
      c[CW-1] = ^{d, c[CW-2:0]};
      return c;
   endfunction

   function automatic int idx_of(int pos);
      int k;
      k = 0;
      for (int q = 3; q < pos; q++) if (!is_pow2(q)) k++;
      return k;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_word(input logic [DW-1:0] d, input logic [CW-1:0] m);
      logic [CW-1:0] e_syn;
      logic          e_single;
      logic          e_double;
      logic [DW-1:0] e_data;
      logic [CW-1:0] e_code;
      int            pos;
      e_syn    = {^m, m[CW-2:0]};
      pos      = int'(m[CW-2:0]);
      e_single = e_syn[CW-1] && (pos <= DW + CW - 1);
      e_double = !e_single && (e_syn != '0);
      e_data   = d;
      e_code   = ref_code(d) ^ m;
      if (e_single && m_cor) begin
         if (pos >= 3 && !is_pow2(pos)) e_data[idx_of(pos)] = ~e_data[idx_of(pos)];
         e_code = ref_code(e_data);
      end
      chk(rd_valid == 1'b1, "R1", "rd_valid", DW'(rd_valid), 64'd1);
      chk(rd_syndrome == e_syn, "R5", "syndrome", DW'(rd_syndrome), DW'(e_syn));
      chk(rd_single == e_single && rd_double == e_double, "R6", "flags {single,double}",
          DW'({rd_single, rd_double}), DW'({e_single, e_double}));
      chk(rd_data == e_data, e_double ? "R9" : (m_cor ? "R8" : "R7"), "rd_data", rd_data, e_data);
      chk(rd_code == e_code, m == '0 ? "R2" : "R3", "rd_code", DW'(rd_code), DW'(e_code));
      if (e_single && m_rpt && !m_logv) begin
         m_logv = 1'b1;
         m_logs = e_syn;
         m_loga = rd_addr;
      end
   endtask

   task automatic check_log(input string req);
      chk(log_valid == m_logv, req, "log_valid", DW'(log_valid), DW'(m_logv));
      if (m_logv) begin
         chk(log_addr == m_loga, req, "log_addr", DW'(log_addr), DW'(m_loga));
         chk(log_syndrome == m_logs, req, "log_syndrome", DW'(log_syndrome), DW'(m_logs));
      end
      chk(irq == (m_logv && m_rpt), "R12", "irq", DW'(irq), DW'(m_logv && m_rpt));
   endtask

   task automatic do_write(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      m_data[a] = d;
      m_wmask[a] = m_mask;
   endtask

   task automatic do_read(input int a);
      @(negedge clk);
      rd_req = 1'b1; rd_addr = AW'(a);
      @(negedge clk);
      rd_req = 1'b0;
      check_word(m_data[a], m_wmask[a]);
      @(negedge clk);
      chk(rd_valid == 1'b0, "R1", "rd_valid after", DW'(rd_valid), 64'd0);
      check_log("R10");
   endtask

   task automatic do_reg(input int sel, input logic [CW-1:0] v);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = 2'(sel); reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
      case (sel)
         0: m_mask = v;
         1: begin m_rpt = v[0]; m_cor = v[1]; end
         2: if (v[0]) m_logv = 1'b0;
         default: ;
      endcase
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", nchk, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      logic [DW-1:0] dnew;
      logic [DW-1:0] dold;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk(rd_valid == 1'b0, "R1", "reset rd_valid", DW'(rd_valid), 64'd0);
      chk(log_valid == 1'b0 && irq == 1'b0, "R12", "reset log/irq", DW'({log_valid, irq}), 64'd0);
      rst_n = 1'b1;

      // R2 R3: clean fill with reset mask of zero
      for (int a = 0; a < DEPTH; a++) do_write(a, {$urandom, $urandom});
      for (int a = 0; a < DEPTH; a++) do_read(a);

      // R4 R7: inject on check bit 0, clear mask, report still off
      do_reg(0, 8'h01);
      do_write(1, {$urandom, $urandom});
      do_reg(0, 8'h00);
      do_read(1);
      // R13: select 3 leaves everything unchanged
      do_reg(3, 8'hFF);
      do_read(1);

      // R10 R12: enable report, first error latched
      do_reg(1, 8'h01);
      do_read(1);
      do_reg(0, 8'h03);
      do_write(2, {$urandom, $urandom});
      do_reg(0, 8'h02);
      do_write(3, {$urandom, $urandom});
      do_reg(0, 8'hC8);
      do_write(6, {$urandom, $urandom});
      do_reg(0, 8'h83);
      do_write(4, {$urandom, $urandom});
      do_reg(0, 8'h85);
      do_write(7, {$urandom, $urandom});
      do_reg(0, 8'h80);
      do_write(8, {$urandom, $urandom});
      do_reg(0, 8'h00);
      do_read(2);
      do_read(3);
      do_read(6);
      // R12: report off drops irq, log kept
      do_reg(1, 8'h00);
      @(negedge clk);
      check_log("R12");
      // R11: clear
      do_reg(2, 8'h01);
      @(negedge clk);
      check_log("R11");

      // R8: repair and report on
      do_reg(1, 8'h03);
      do_read(4);
      do_read(7);
      do_read(8);
      do_read(3);
      // R9: double with repair on
      do_read(2);
      do_read(6);

      // R11: clear and capture on the same edge; log holds addr 4 now
      @(negedge clk);
      rd_req = 1'b1; rd_addr = AW'(1);
      @(negedge clk);
      rd_req = 1'b0;
      reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 8'h01;
      @(negedge clk);
      reg_we = 1'b0;
      m_logv = 1'b1; m_loga = AW'(1); m_logs = 8'h81;
      check_log("R11");

      // R1: same-cycle write and read to one location returns old word
      dold = m_data[5];
      dnew = {$urandom, $urandom};
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(5); wr_data = dnew;
      rd_req = 1'b1; rd_addr = AW'(5);
      @(negedge clk);
      wr_en = 1'b0; rd_req = 1'b0;
      chk(rd_data == dold, "R1", "read-before-write", rd_data, dold);
      m_data[5] = dnew;
      m_wmask[5] = m_mask;
      do_read(5);

      // random mix
      for (int n = 0; n < 600; n++) begin
         int op;
         op = int'($urandom % 10);
         if (op < 3) begin
            int r;
            r = int'($urandom % 4);
            if (r == 0)      do_reg(0, 8'h00);
            else if (r == 1) do_reg(0, CW'(1) << ($urandom % CW));
            else if (r == 2) do_reg(0, 8'h80 | CW'(3 + $urandom % 69));
            else             do_reg(0, CW'($urandom));
            do_write(int'($urandom % DEPTH), {$urandom, $urandom});
         end else if (op < 8) begin
            do_read(int'($urandom % DEPTH));
         end else if (op == 8) begin
            do_reg(1, CW'($urandom % 4));
         end else begin
            do_reg(2, 8'h01);
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule